// File: doc/BRIEF.md
# NAND Sector Hamming ECC Corrector

This block checks one NAND sector against its error-correcting code. It takes the code read back from the spare area and the code computed while the sector data streamed in, forms their XOR syndrome, and sorts the outcome into one of four classes: clean, corrupt code field, single data-bit error that can be repaired, or damage that cannot be repaired. For a repairable error it reports the byte and bit to invert, so the surrounding logic can flip that bit in its sector buffer.

Each code covers 256 data bytes. It is 22 bits wide: an 11-bit parity half and an 11-bit complementary parity half, packed into three bytes. In wide mode a 512-byte sector is treated as two 256-byte halves. Each half has its own three-byte code and is judged on its own. The byte index for the upper half is shifted up by 256, and the two error flags are merged into one. A pulse on `start_i` samples the inputs, and the registered result appears with `valid_o` on the next cycle. The result then holds until the next start.

Top module: `nand_ecc_fixer`

## Requirements
- R1: Code byte k sits at bits 8k+7:8k of `calc_code_i` and `stored_code_i`. Bytes 0 to 2 form the lower-half code, with byte 0 as its least significant byte. Bytes 3 to 5 form the upper-half code in the same order. All 24 bits of a code take part in the syndrome, and the upper parity half is bits 21:11.
- R2: `valid_o` is 1 in exactly the cycle after a cycle with `start_i` high, and 0 otherwise.
- R3: A zero syndrome (the two codes are equal) gives status 0 (clean) for that half.
- R4: If the computed code or the stored code of a half is all zero, that half reports status 0 with byte and bit indices 0, whatever the syndrome.
- R5: A syndrome with exactly one bit set gives status 1 (code field error). Byte and bit indices are 0.
- R6: A syndrome with exactly 11 set bits, whose bits 10:0 XOR bits 21:11 equal 0x7FF, gives status 2 (repairable). The bit index is syndrome bits 2:0, and the byte index is syndrome bits 10:3.
- R7: Every other nonzero syndrome gives status 3 (unrepairable), with byte and bit indices 0.
- R8: With `wide_i` high, the upper half is judged from bytes 3 to 5, and its repairable byte index is 256 plus syndrome bits 10:3. With `wide_i` low, the upper half reports status 0 with indices 0, whatever its code bytes hold.
- R9: `fail_o` is 1 exactly when a judged half has status 1 or 3. A repairable or clean half does not set it.
- R10: During and right after reset, `valid_o` and `fail_o` are 0, and all statuses and indices are 0.
- R11: Outputs keep their values in every cycle after one without `start_i`, even if the code inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Sample codes and mode this cycle |
| wide_i | input | 1 | 1: 512-byte sector as two halves; 0: 256-byte sector |
| calc_code_i | input | 48 | Computed code bytes 0..5, byte k at bits 8k+7:8k |
| stored_code_i | input | 48 | Stored code bytes 0..5, byte k at bits 8k+7:8k |
| valid_o | output | 1 | Result strobe, one cycle after start |
| fail_o | output | 1 | Code field error or unrepairable error in a judged half |
| lo_status_o | output | 2 | Lower-half status: 0 clean, 1 code error, 2 repairable, 3 unrepairable |
| lo_byte_o | output | 9 | Lower-half failing byte index |
| lo_bit_o | output | 3 | Lower-half failing bit index |
| hi_status_o | output | 2 | Upper-half status, same encoding |
| hi_byte_o | output | 9 | Upper-half failing byte index (256..511 when repairable) |
| hi_bit_o | output | 3 | Upper-half failing bit index |

## Verification
The bench builds the block with its default parameters: three-byte codes (CODE_W 24) and 11-bit parity halves (HALF_W 11). This exposes the real 22-bit pairing rule and the two spare bits at the top of byte 2.

The vectors place repairable errors at the extreme locations (byte 0 bit 0, byte 255 bit 7) and at an interior one. They also cover:
- a one-bit syndrome in a spare bit;
- an 11-bit syndrome that fails the complement test;
- each all-zero code exemption.

Wide-mode vectors show the 256 offset and the merged flag. Narrow-mode vectors fill the upper code bytes with garbage, so that any leakage from the unused half would show.

// File: rtl/necc_pkg.sv
package necc_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_CODE   = 2'd1,
    ST_FIXED  = 2'd2,
    ST_UNCORR = 2'd3
  } necc_status_e;
endpackage

// File: rtl/necc_popcount.sv
module necc_popcount #(
  parameter int WIDTH = 24,
  localparam int LEVELS = $clog2(WIDTH),
  localparam int LEAVES = 1 << LEVELS,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] data_i,
  output logic [CW-1:0]    count_o
);
  // heap-ordered adder tree: node k sums children 2k+1 and 2k+2
  logic [CW-1:0] node [2*LEAVES-1];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < WIDTH) begin : g_bit
      assign node[LEAVES-1+i] = CW'(data_i[i]);
    end else begin : g_pad
      assign node[LEAVES-1+i] = '0;
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_sum
    assign node[k] = node[2*k+1] + node[2*k+2];
  end

  assign count_o = node[0];
endmodule

// File: rtl/necc_classify.sv
module necc_classify
  import necc_pkg::*;
#(
  parameter int CODE_W = 24,
  parameter int HALF_W = 11
) (
  input  logic [CODE_W-1:0] calc_i,
  input  logic [CODE_W-1:0] stored_i,
  output necc_status_e      status_o,
  output logic [HALF_W-1:0] loc_o
);
  localparam int CW = $clog2(CODE_W + 1);

  logic [CODE_W-1:0] syn;
  logic [CW-1:0]     weight;
  logic [HALF_W-1:0] pair;

  assign syn  = calc_i ^ stored_i;
  assign pair = syn[HALF_W-1:0] ^ syn[2*HALF_W-1:HALF_W];

  necc_popcount #(.WIDTH(CODE_W)) u_pop (
    .data_i (syn),
    .count_o(weight)
  );

  always_comb begin
    status_o = ST_CLEAN;
    loc_o    = '0;
    if (syn == '0 || calc_i == '0 || stored_i == '0) begin
      status_o = ST_CLEAN;
    end else if (weight == CW'(1)) begin
      status_o = ST_CODE;
    end else if (weight == CW'(HALF_W) && (&pair)) begin
      status_o = ST_FIXED;
      loc_o    = syn[HALF_W-1:0];
    end else begin
      status_o = ST_UNCORR;
    end
  end

  // p_fixed_weight_r6: tree weight must agree with a direct count
  always_comb begin
    if (status_o == ST_FIXED)
      p_fixed_weight_r6: assert ($countones(syn) == HALF_W);
    if (status_o == ST_CODE)
      p_code_onehot_r5: assert ($onehot(syn));
  end
endmodule

// File: rtl/nand_ecc_fixer.sv
module nand_ecc_fixer
  import necc_pkg::*;
#(
  parameter int CODE_W = 24,
  parameter int HALF_W = 11
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  wide_i,
  input  logic [2*CODE_W-1:0]   calc_code_i,
  input  logic [2*CODE_W-1:0]   stored_code_i,
  output logic                  valid_o,
  output logic                  fail_o,
  output logic [1:0]            lo_status_o,
  output logic [HALF_W-3:0]     lo_byte_o,
  output logic [2:0]            lo_bit_o,
  output logic [1:0]            hi_status_o,
  output logic [HALF_W-3:0]     hi_byte_o,
  output logic [2:0]            hi_bit_o
);
  localparam int HALVES = 2;
  localparam int BYTE_W = HALF_W - 2;

  necc_status_e       st_d   [HALVES];
  logic [BYTE_W-1:0]  byte_d [HALVES];
  logic [2:0]         bit_d  [HALVES];
  logic [HALVES-1:0]  err_d;

  necc_status_e       st_q   [HALVES];
  logic [BYTE_W-1:0]  byte_q [HALVES];
  logic [2:0]         bit_q  [HALVES];
  logic               fail_q, valid_q;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    necc_status_e      raw_st;
    logic [HALF_W-1:0] loc;
    logic              judged;

    necc_classify #(.CODE_W(CODE_W), .HALF_W(HALF_W)) u_cls (
      .calc_i  (calc_code_i[h*CODE_W +: CODE_W]),
      .stored_i(stored_code_i[h*CODE_W +: CODE_W]),
      .status_o(raw_st),
      .loc_o   (loc)
    );

    assign judged    = (h == 0) || wide_i;
    assign st_d[h]   = judged ? raw_st : ST_CLEAN;
    assign byte_d[h] = (judged && raw_st == ST_FIXED) ? {1'(h), loc[HALF_W-1:3]} : '0;
    assign bit_d[h]  = (judged && raw_st == ST_FIXED) ? loc[2:0] : '0;
    assign err_d[h]  = st_d[h] == ST_CODE || st_d[h] == ST_UNCORR;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[h]   <= ST_CLEAN;
        byte_q[h] <= '0;
        bit_q[h]  <= '0;
      end else if (start_i) begin
        st_q[h]   <= st_d[h];
        byte_q[h] <= byte_d[h];
        bit_q[h]  <= bit_d[h];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      valid_q <= start_i;
      if (start_i) fail_q <= |err_d;
    end
  end

  assign valid_o     = valid_q;
  assign fail_o      = fail_q;
  assign lo_status_o = st_q[0];
  assign lo_byte_o   = byte_q[0];
  assign lo_bit_o    = bit_q[0];
  assign hi_status_o = st_q[1];
  assign hi_byte_o   = byte_q[1];
  assign hi_bit_o    = bit_q[1];

  p_valid_follows_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  p_valid_only_after_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  p_fail_matches_status_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o == (lo_status_o inside {2'd1, 2'd3} || hi_status_o inside {2'd1, 2'd3}));
  p_loc_zero_unless_fixed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_status_o != 2'd2 |-> (lo_byte_o == '0 && lo_bit_o == '0));
  p_hi_offset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_status_o == 2'd2 |-> hi_byte_o[BYTE_W-1]);
  p_lo_no_offset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_byte_o[BYTE_W-1]);
  p_narrow_hi_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !wide_i) |=> (hi_status_o == 2'd0 && hi_byte_o == '0));
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(lo_status_o) && $stable(hi_status_o) && $stable(fail_o)
                  && $stable(lo_byte_o) && $stable(hi_byte_o)));
endmodule

// File: tb/sim_nand_ecc_fixer.sv
module sim_nand_ecc_fixer;
  typedef struct packed {
    logic        wide;
    logic [47:0] calc;
    logic [47:0] stored;
    logic [1:0]  lo_st;
    logic [8:0]  lo_byte;
    logic [2:0]  lo_bit;
    logic [1:0]  hi_st;
    logic [8:0]  hi_byte;
    logic [2:0]  hi_bit;
    logic        fail;
  } vec_t;

  localparam int NV = 15;
  // status: 0 clean, 1 code error, 2 repairable, 3 unrepairable
  localparam vec_t VECS [NV] = '{
    // R3 equal codes
    '{1'b0, 48'h000000_155555, 48'h000000_155555, 2'd0, 9'd0, 3'd0, 2'd0, 9'd0, 3'd0, 1'b0},
    // R6 byte 5 bit 3
    '{1'b0, 48'h000000_2BF57E, 48'h000000_155555, 2'd2, 9'd5, 3'd3, 2'd0, 9'd0, 3'd0, 1'b0},
    // R6 byte 255 bit 7
    '{1'b0, 48'h000000_1552AA, 48'h000000_155555, 2'd2, 9'd255, 3'd7, 2'd0, 9'd0, 3'd0, 1'b0},
    // R6 byte 0 bit 0
    '{1'b0, 48'h000000_2AAD55, 48'h000000_155555, 2'd2, 9'd0, 3'd0, 2'd0, 9'd0, 3'd0, 1'b0},
    // R5 single syndrome bit 10
    '{1'b0, 48'h000000_155155, 48'h000000_155555, 2'd1, 9'd0, 3'd0, 2'd0, 9'd0, 3'd0, 1'b1},
    // R5/R1 single syndrome bit 23 (spare bit of byte 2)
    '{1'b0, 48'h000000_955555, 48'h000000_155555, 2'd1, 9'd0, 3'd0, 2'd0, 9'd0, 3'd0, 1'b1},
    // R7 two-bit syndrome
    '{1'b0, 48'h000000_155556, 48'h000000_155555, 2'd3, 9'd0, 3'd0, 2'd0, 9'd0, 3'd0, 1'b1},
    // R7 eleven ones, halves not complementary
    '{1'b0, 48'h000000_5556AA, 48'h000000_155555, 2'd3, 9'd0, 3'd0, 2'd0, 9'd0, 3'd0, 1'b1},
    // R4 computed code zero
    '{1'b0, 48'h000000_000000, 48'h000000_123456, 2'd0, 9'd0, 3'd0, 2'd0, 9'd0, 3'd0, 1'b0},
    // R4 stored code zero
    '{1'b0, 48'h000000_2BF57E, 48'h000000_000000, 2'd0, 9'd0, 3'd0, 2'd0, 9'd0, 3'd0, 1'b0},
    // R8 narrow: upper bytes garbage, ignored
    '{1'b0, 48'h955555_155555, 48'h155555_155555, 2'd0, 9'd0, 3'd0, 2'd0, 9'd0, 3'd0, 1'b0},
    // R8 wide: upper repairable byte 261 bit 3
    '{1'b1, 48'h2BF57E_155555, 48'h155555_155555, 2'd0, 9'd0, 3'd0, 2'd2, 9'd261, 3'd3, 1'b0},
    // R9 wide: lower code error, upper unrepairable
    '{1'b1, 48'h155556_155155, 48'h155555_155555, 2'd1, 9'd0, 3'd0, 2'd3, 9'd0, 3'd0, 1'b1},
    // R9 wide: upper code error only
    '{1'b1, 48'h955555_1552AA, 48'h155555_155555, 2'd2, 9'd255, 3'd7, 2'd1, 9'd0, 3'd0, 1'b1},
    // R8 wide: both repairable, upper byte 511 bit 7
    '{1'b1, 48'h1552AA_2AAD55, 48'h155555_155555, 2'd2, 9'd0, 3'd0, 2'd2, 9'd511, 3'd7, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [47:0] calc_code_i = '0;
  logic [47:0] stored_code_i = '0;
  logic        valid_o, fail_o;
  logic [1:0]  lo_status_o, hi_status_o;
  logic [8:0]  lo_byte_o, hi_byte_o;
  logic [2:0]  lo_bit_o, hi_bit_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  nand_ecc_fixer u0 (
    .clk_i, .rst_ni, .start_i, .wide_i, .calc_code_i, .stored_code_i,
    .valid_o, .fail_o, .lo_status_o, .lo_byte_o, .lo_bit_o,
    .hi_status_o, .hi_byte_o, .hi_bit_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input vec_t v);
    check({req, " lo_status"}, 32'(lo_status_o), 32'(v.lo_st));
    check({req, " lo_byte"},   32'(lo_byte_o),   32'(v.lo_byte));
    check({req, " lo_bit"},    32'(lo_bit_o),    32'(v.lo_bit));
    check({req, " hi_status"}, 32'(hi_status_o), 32'(v.hi_st));
    check({req, " hi_byte"},   32'(hi_byte_o),   32'(v.hi_byte));
    check({req, " hi_bit"},    32'(hi_bit_o),    32'(v.hi_bit));
    check({req, " fail"},      32'(fail_o),      32'(v.fail));
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk_i);
    wide_i = v.wide;
    calc_code_i = v.calc;
    stored_code_i = v.stored;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  initial begin
    // R10 reset state
    #5;
    check("R10 valid in reset", 32'(valid_o), 32'd0);
    check("R10 fail in reset", 32'(fail_o), 32'd0);
    check("R10 status in reset", 32'({lo_status_o, hi_status_o}), 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 valid after reset", 32'(valid_o), 32'd0);
    check("R10 indices after reset", 32'({lo_byte_o, hi_byte_o, lo_bit_o, hi_bit_o}), 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check($sformatf("R2 valid vec %0d", i), 32'(valid_o), 32'd1);
      check_vec($sformatf("R1/R3-R9 vec %0d", i), VECS[i]);
    end

    // R11 hold: change inputs without start
    apply(VECS[1]);
    calc_code_i = VECS[12].calc;
    stored_code_i = VECS[12].stored;
    wide_i = 1'b1;
    @(negedge clk_i);
    check("R2 no valid without start", 32'(valid_o), 32'd0);
    check_vec("R11 hold", VECS[1]);
    @(negedge clk_i);
    check_vec("R11 hold second cycle", VECS[1]);

    // R2 back-to-back starts
    @(negedge clk_i);
    wide_i = VECS[11].wide; calc_code_i = VECS[11].calc; stored_code_i = VECS[11].stored;
    start_i = 1'b1;
    @(negedge clk_i);
    check("R2 back-to-back first valid", 32'(valid_o), 32'd1);
    check_vec("R8 back-to-back first", VECS[11]);
    wide_i = VECS[6].wide; calc_code_i = VECS[6].calc; stored_code_i = VECS[6].stored;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R2 back-to-back second valid", 32'(valid_o), 32'd1);
    check_vec("R7 back-to-back second", VECS[6]);

    // R10 asynchronous reset clears results
    @(negedge clk_i);
    rst_ni = 1'b0;
    #3;
    check("R10 async reset status", 32'({lo_status_o, fail_o}), 32'd0);
    rst_ni = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule